// File: doc/BRIEF.md
# Multiplexed Grid Strobe and Dimming Timer

This block sequences the grids of a two- or three-grid multiplexed display and gates the segment data for whichever grid is current. A free-running oscillator enable is divided into bit times of four oscillator periods. Each grid owns a slot of 1024 bit times. The grid strobe is asserted for the first 1016 bit times of its slot and released for the last 8, which leaves a blanking gap before the next grid. The segments for that grid are enabled from the start of the slot for a number of bit times set by a 10-bit dimming value. The segment on-time is capped at the grid's active window.

A static mode input picks two slots per frame (high) or three slots per frame (low). The block takes one segment word per grid and the dimming value from latches held elsewhere. It drives active-low grid strobes, the gated segment word, a pulse that marks the segment-enable window, and a two-bit slot code. A slave driver can use the pulse and the slot code to follow the same timing.

Top module: `vfd_grid_timer`

## Requirements
- R1: The slot position advances by one bit time on every fourth cycle in which `osc_en` is high. Cycles with `osc_en` low do not advance the prescaler or the position.
- R2: A slot lasts 1024 bit times. Slots run in the order grid 1, grid 2, grid 3. `duplex` = 1 gives two slots per frame and `duplex` = 0 gives three. `slot_code` carries the current slot as binary 0, 1 or 2.
- R3: `grid_n[g]` is low only while slot g is current and the position within the slot is below 1016. During the last 8 bit times of every slot, all grid strobes are high. At most one strobe is low at a time.
- R4: The segments are enabled while the position is below min(`dim_level`, 1016), counted from position 0 of the slot. A `dim_level` of 0 keeps every segment low.
- R5: Every `dim_level` from 1016 to 1023 gives the same on-window of 1016 bit times.
- R6: `seg_out` equals the segment word of the current grid (`seg_g1`, `seg_g2` or `seg_g3`) while the segments are enabled, and is all zero otherwise. A change of the word is visible in the same cycle.
- R7: `dim_pulse` is high exactly while the segments are enabled.
- R8: Synchronous reset sets the prescaler to 0, the position to 0 and the slot to grid 1. After reset, `grid_n` = 3'b110 and `slot_code` = 0. With a zero dimming level, `seg_out` is all zero.
- R9: If `duplex` is raised while grid 3's slot is current, that slot runs to its end and the sequence then returns to grid 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One-cycle enable per oscillator period |
| duplex | input | 1 | 1: two grids per frame, 0: three grids |
| dim_level | input | 10 | Segment on-time in bit times per slot |
| seg_g1 | input | 32 | Latched segment word for grid 1 |
| seg_g2 | input | 32 | Latched segment word for grid 2 |
| seg_g3 | input | 32 | Latched segment word for grid 3 |
| grid_n | output | 3 | Active-low grid strobes, bit 0 is grid 1 |
| seg_out | output | 32 | Gated segment word |
| dim_pulse | output | 1 | High during the segment-enable window |
| slot_code | output | 2 | Index of the current slot for a slave driver |

## Verification
The outputs are combinational functions of the position and slot registers and of the data inputs. A change of `dim_level` or of a segment word therefore shows in the same cycle. An `osc_en` pulse only moves the outputs after the clock edge that completes the fourth such pulse. The bench keeps its own prescaler, position and slot integers and updates them at each rising edge. It compares every output one time unit after the falling edge, when inputs driven at that edge have settled. Two directed checks measure clock cycles between slot-code changes: 8192 when `osc_en` is high every other cycle, and 4096 when it is always high. A change of the mode input or of a segment word is checked in the slot, or the cycle, where the requirement says it takes effect.

// File: rtl/vfd_grid_pkg.sv
package vfd_grid_pkg;

    localparam int SLOT_W    = 10;
    localparam int SLOT_LEN  = 1 << SLOT_W;
    localparam int MAX_GRIDS = 3;

    typedef logic [SLOT_W-1:0] slot_pos_t;

    typedef enum logic [1:0] {
        SLOT_G1 = 2'd0,
        SLOT_G2 = 2'd1,
        SLOT_G3 = 2'd2
    } slot_id_e;

    typedef struct packed {
        slot_id_e  slot;
        slot_pos_t pos;
    } frame_state_t;

    typedef struct packed {
        logic grid_on;
        logic seg_on;
    } window_t;

    // slot order: grid 1, grid 2, then grid 3 only in three-grid frames
    function automatic slot_id_e next_slot(slot_id_e cur, logic two_grid);
        if (cur == SLOT_G1) return SLOT_G2;
        if (cur == SLOT_G2 && !two_grid) return SLOT_G3;
        return SLOT_G1;
    endfunction

    // segment on-window saturates at the grid's active window
    function automatic slot_pos_t on_limit(slot_pos_t dim, slot_pos_t active);
        return (dim > active) ? active : dim;
    endfunction

endpackage

// File: rtl/vfd_bit_prescaler.sv
module vfd_bit_prescaler #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_en,
    output logic bit_tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pcnt;

    assign bit_tick = osc_en && (pcnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
        end else if (osc_en) begin
            pcnt <= (pcnt == LAST) ? '0 : pcnt + 1'b1;
        end
    end

    // R1: a bit tick never repeats on the next cycle
    a_r1_tick_gap: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> !bit_tick);

    // R1: with no oscillator pulse the prescaler holds
    a_r1_hold_no_osc: assert property (@(posedge clk) disable iff (rst)
        !osc_en |=> $stable(pcnt));

endmodule

// File: rtl/vfd_slot_sequencer.sv
module vfd_slot_sequencer
    import vfd_grid_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_tick,
    input  logic         duplex,
    output frame_state_t st
);
    logic slot_end;

    assign slot_end = bit_tick && (st.pos == slot_pos_t'(SLOT_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st.slot <= SLOT_G1;
            st.pos  <= '0;
        end else if (bit_tick) begin
            st.pos <= st.pos + 1'b1;
            if (slot_end) begin
                st.slot <= next_slot(st.slot, duplex);
            end
        end
    end

    // R2: the slot code never takes the unused value
    a_r2_slot_legal: assert property (@(posedge clk) disable iff (rst)
        st.slot != slot_id_e'(2'd3));

    // R2: position and slot move only on a bit tick
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(st));

    // R9: a two-grid frame leaving grid 2 or grid 3 returns to grid 1
    a_r9_duplex_return: assert property (@(posedge clk) disable iff (rst)
        (slot_end && duplex && st.slot != SLOT_G1) |=> st.slot == SLOT_G1);

    // R2: a slot end moves to a different slot
    a_r2_slot_changes: assert property (@(posedge clk) disable iff (rst)
        slot_end |=> st.slot != $past(st.slot));

endmodule

// File: rtl/vfd_segment_gate.sv
module vfd_segment_gate
    import vfd_grid_pkg::*;
#(
    parameter int NSEG        = 32,
    parameter int ACTIVE_BITS = 1016
) (
    input  frame_state_t                   st,
    input  slot_pos_t                      dim,
    input  logic [MAX_GRIDS-1:0][NSEG-1:0] seg_lat,
    output logic [MAX_GRIDS-1:0]           grid_n,
    output logic [NSEG-1:0]                seg_out,
    output logic                           dim_pulse,
    output logic [1:0]                     sync
);
    localparam slot_pos_t ACTIVE = slot_pos_t'(ACTIVE_BITS);

    window_t          win;
    logic [NSEG-1:0]  cur_word;

    always_comb begin
        win.grid_on = (st.pos < ACTIVE);
        win.seg_on  = (st.pos < on_limit(dim, ACTIVE));
    end

    for (genvar g = 0; g < MAX_GRIDS; g++) begin : g_strobe
        assign grid_n[g] = ~(win.grid_on && (st.slot == slot_id_e'(2'(g))));
    end

    always_comb begin
        unique case (st.slot)
            SLOT_G2: cur_word = seg_lat[1];
            SLOT_G3: cur_word = seg_lat[2];
            default: cur_word = seg_lat[0];
        endcase
    end

    assign seg_out   = win.seg_on ? cur_word : '0;
    assign dim_pulse = win.seg_on;
    assign sync      = st.slot;

endmodule

// File: rtl/vfd_grid_timer.sv
module vfd_grid_timer
    import vfd_grid_pkg::*;
#(
    parameter int NSEG        = 32,
    parameter int PRESCALE    = 4,
    parameter int ACTIVE_BITS = 1016
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_en,
    input  logic              duplex,
    input  logic [SLOT_W-1:0] dim_level,
    input  logic [NSEG-1:0]   seg_g1,
    input  logic [NSEG-1:0]   seg_g2,
    input  logic [NSEG-1:0]   seg_g3,
    output logic [2:0]        grid_n,
    output logic [NSEG-1:0]   seg_out,
    output logic              dim_pulse,
    output logic [1:0]        slot_code
);
    logic                           bit_tick;
    frame_state_t                   st;
    logic [MAX_GRIDS-1:0][NSEG-1:0] lat;

    assign lat[0] = seg_g1;
    assign lat[1] = seg_g2;
    assign lat[2] = seg_g3;

    vfd_bit_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk      (clk),
        .rst      (rst),
        .osc_en   (osc_en),
        .bit_tick (bit_tick)
    );

    vfd_slot_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (bit_tick),
        .duplex   (duplex),
        .st       (st)
    );

    vfd_segment_gate #(.NSEG(NSEG), .ACTIVE_BITS(ACTIVE_BITS)) u_gate (
        .st        (st),
        .dim       (dim_level),
        .seg_lat   (lat),
        .grid_n    (grid_n),
        .seg_out   (seg_out),
        .dim_pulse (dim_pulse),
        .sync      (slot_code)
    );

    // R3: never more than one grid strobe low
    a_r3_single_grid: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~grid_n));

    // R3: the low strobe belongs to the slot the code reports
    a_r3_grid_matches_code: assert property (@(posedge clk) disable iff (rst)
        (grid_n != 3'b111) |-> (grid_n[slot_code] == 1'b0));

    // R4: segments light only inside a grid's active window
    a_r4_seg_in_grid: assert property (@(posedge clk) disable iff (rst)
        (|seg_out) |-> (grid_n != 3'b111));

    // R7: the dimming pulse stays inside the active window
    a_r7_pulse_in_grid: assert property (@(posedge clk) disable iff (rst)
        dim_pulse |-> (grid_n != 3'b111));

    // R6: lit segments imply the enable window is open
    a_r6_seg_needs_pulse: assert property (@(posedge clk) disable iff (rst)
        (|seg_out) |-> dim_pulse);

    // R8: after a reset edge grid 1 is selected and slot 0 reported
    a_r8_reset_state: assert property (@(posedge clk)
        rst |=> (grid_n == 3'b110 && slot_code == 2'd0));

endmodule

// File: tb/vfd_grid_timer_tb.sv
module vfd_grid_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        osc_en = 1'b0;
    logic        duplex = 1'b1;
    logic [9:0]  dim_level = '0;
    logic [31:0] seg_g1 = '0, seg_g2 = '0, seg_g3 = '0;
    logic [2:0]  grid_n;
    logic [31:0] seg_out;
    logic        dim_pulse;
    logic [1:0]  slot_code;

    always #2.5 clk = ~clk;

    vfd_grid_timer u_dut (
        .clk(clk), .rst(rst), .osc_en(osc_en), .duplex(duplex),
        .dim_level(dim_level), .seg_g1(seg_g1), .seg_g2(seg_g2),
        .seg_g3(seg_g3), .grid_n(grid_n), .seg_out(seg_out),
        .dim_pulse(dim_pulse), .slot_code(slot_code)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int m_pre = 0, m_pos = 0, m_slot = 0;
    int osc_pat = 0;
    bit done = 0;

    // behavioural reference: plain integers updated at every rising edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_pre = 0; m_pos = 0; m_slot = 0;
        end else if (osc_en) begin
            if (m_pre == 3) begin
                m_pre = 0;
                if (m_pos == 1023) begin
                    m_pos = 0;
                    if (duplex) m_slot = (m_slot == 0) ? 1 : 0;
                    else        m_slot = (m_slot + 1) % 3;
                end else begin
                    m_pos = m_pos + 1;
                end
            end else begin
                m_pre = m_pre + 1;
            end
        end
    end

    task automatic check(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            if (n_bad < 20)
                $display("FAIL %s %s at cycle %0d: actual %0h expected %0h",
                         req, what, cyc, act, exp);
        end
    endtask

    // cycle-by-cycle compare, sampled after the falling-edge input updates
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            int lim;
            logic [2:0]  eg;
            logic        en;
            logic [31:0] word;
            lim = (dim_level > 10'd1016) ? 1016 : int'(dim_level);
            en  = (m_pos < lim);
            for (int g = 0; g < 3; g++) eg[g] = !((m_pos < 1016) && (m_slot == g));
            word = (m_slot == 0) ? seg_g1 : (m_slot == 1) ? seg_g2 : seg_g3;
            check("R3", "grid_n", grid_n, eg);
            check("R6", "seg_out", seg_out, en ? word : 32'h0);
            check("R7", "dim_pulse", dim_pulse, en);
            check("R2", "slot_code", slot_code, m_slot);
        end
    end

    // oscillator enable pattern: 0 always high, 1 every other cycle
    always @(negedge clk) begin
        if (osc_pat == 0) osc_en <= 1'b1;
        else              osc_en <= ~osc_en;
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure_slot(int exp_len, string req);
        int t0;
        logic [1:0] s;
        s = slot_code;
        while (slot_code == s) @(negedge clk);
        t0 = cyc; s = slot_code;
        while (slot_code == s) @(negedge clk);
        check(req, "slot length in cycles", cyc - t0, exp_len);
    endtask

    initial begin
        run(3);
        #1;
        // R8: reset state visible while reset is held
        check("R8", "reset grid_n", grid_n, 3'b110);
        check("R8", "reset seg_out", seg_out, 32'h0);
        check("R8", "reset slot_code", slot_code, 2'd0);
        @(negedge clk);
        seg_g1 = 32'h0000_00FF; seg_g2 = 32'hA5A5_0F0F; seg_g3 = 32'h8000_0001;
        rst = 1'b0;

        // R2 R3: duplex frames at full duty
        dim_level = 10'd1016;
        run(18000);
        // R4: partial duty in duplex
        dim_level = 10'd64;
        run(9000);
        // R5: values above 1016 saturate; triplex frames
        duplex = 1'b0;
        dim_level = 10'd1023;
        run(13000);
        // R4: zero duty keeps segments dark
        dim_level = 10'd0;
        run(13000);
        #1;
        check("R4", "seg_out at zero duty", seg_out, 32'h0);
        // R1: gapped oscillator enable doubles the slot length
        dim_level = 10'd1;
        osc_pat = 1;
        measure_slot(8192, "R1");
        run(4000);
        osc_pat = 0;
        measure_slot(4096, "R1");
        // R9: raise duplex while grid 3 is current
        while (slot_code != 2'd2) @(negedge clk);
        duplex = 1'b1;
        dim_level = 10'd1015;
        #1;
        check("R9", "slot while grid 3 finishes", slot_code, 2'd2);
        while (slot_code == 2'd2) @(negedge clk);
        #1;
        check("R9", "slot after grid 3 in duplex", slot_code, 2'd0);
        run(9000);
        // R6: segment word change shows in the same cycle
        while (!(dim_pulse && slot_code == 2'd1)) @(negedge clk);
        seg_g2 = 32'h1234_5678;
        #1;
        check("R6", "seg_out follows new word", seg_out, 32'h1234_5678);
        run(6000);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule